// File: doc/BRIEF.md
# Debug Trigger Fire Gate

This block sits between the trigger match logic of a hart and the unit that takes a trigger's action. It receives the raw match indications of three trigger kinds (memory-access match, instruction-count and trap) and decides whether each one may fire. A trigger whose action is "raise a breakpoint exception" must not fire while the hart is already running a trap handler at the privilege level that would receive the breakpoint. Without this check, the handler could take a breakpoint exception inside itself and re-enter. The block detects this from the interrupt-enable bit of the level that takes the breakpoint. Whether that level is machine, supervisor or virtual supervisor depends on the current privilege, the virtualization flag and the breakpoint delegation bits.

For trap triggers the block also decodes the trap cause. The top bit of the cause selects interrupt or exception. The remaining bits are an index into the interrupt or exception select vector programmed for the trigger. A trap hit is flagged as taking effect after the trapping event. The gate itself is combinational. All fire outputs are registered once, so each output reflects the inputs present at the previous rising clock edge.

Top module: `trig_fire_gate`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, all outputs are 0.
- R2: When `act_code` is not 0, each fire output equals its raw hit condition, whatever the privilege, enable and delegation inputs.
- R3: With `act_code` = 0 in machine mode (`priv` = 2'b11), a hit fires only when `m_ie` is 1.
- R4: With `act_code` = 0 in supervisor mode (`priv` = 2'b01) and `virt` = 0, a hit is blocked exactly when bit 3 of `m_edeleg` is 1 and `s_ie` is 0.
- R5: With `act_code` = 0 in supervisor mode and `virt` = 1, a hit is blocked exactly when bit 3 of `m_edeleg` and bit 3 of `h_edeleg` are both 1 and `vs_ie` is 0.
- R6: In user mode (`priv` = 2'b00), and for the unused code 2'b10, the privilege gate never blocks.
- R7: `mem_fire` is the memory hit ANDed with the gate. `icnt_fire` requires `icnt_hit`, `icnt_ctx_ok` and the gate together.
- R8: For trap triggers, bit XLEN-1 of `trap_cause` chooses `trap_irq_sel` (1) or `trap_exc_sel` (0). The other bits, with that bit cleared, form the index of the select bit that must be 1. `trap_valid` must also be 1.
- R9: A trap cause index of XLEN or more never produces a trap hit.
- R10: `fire_after` is 1 exactly when `trap_fire` is 1.
- R11: Every output updates one clock after the inputs that produce it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| virt | input | 1 | Virtualization mode active |
| m_ie | input | 1 | Machine interrupt enable |
| s_ie | input | 1 | Supervisor interrupt enable |
| vs_ie | input | 1 | Virtual-supervisor interrupt enable |
| m_edeleg | input | XLEN | Machine exception delegation vector |
| h_edeleg | input | XLEN | Hypervisor exception delegation vector |
| act_code | input | 4 | Trigger action, 0 = breakpoint exception |
| mem_hit | input | 1 | Raw memory-access match |
| icnt_hit | input | 1 | Raw instruction-count hit |
| icnt_ctx_ok | input | 1 | Common mode/context match of the count trigger |
| trap_valid | input | 1 | A trap is being taken this cycle |
| trap_cause | input | XLEN | Cause of that trap |
| trap_irq_sel | input | XLEN | Interrupt causes the trap trigger selects |
| trap_exc_sel | input | XLEN | Exception causes the trap trigger selects |
| mem_fire | output | 1 | Memory trigger fires |
| icnt_fire | output | 1 | Instruction-count trigger fires |
| trap_fire | output | 1 | Trap trigger fires |
| fire_after | output | 1 | Fire takes effect after the event |

## Verification
Directed vectors walk each privilege level through every combination of enable and delegation bit. Pairs that differ in one bit show which input each blocking rule depends on. The same blocked states are repeated with a non-zero action, which shows that the gate applies only to breakpoint actions. Trap causes with the top bit set and clear, and with both select vectors loaded, show that the top bit picks the vector. Indices just below and above XLEN show the range check. Random vectors are then compared on every clock against a behavioural model, which catches latency and combination errors.

// File: rtl/trig_fire_gate_pkg.sv
package trig_fire_gate_pkg;
  typedef enum logic [1:0] {
    PRIV_USER = 2'b00,
    PRIV_SUPV = 2'b01,
    PRIV_RSVD = 2'b10,
    PRIV_MACH = 2'b11
  } priv_e;

  localparam int unsigned ACT_W      = 4;
  localparam logic [ACT_W-1:0] ACT_BREAKPOINT = '0;
  localparam int unsigned BP_CAUSE   = 3;
endpackage

// File: rtl/trig_reentry_guard.sv
module trig_reentry_guard
  import trig_fire_gate_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [1:0]       priv,
  input  logic             virt,
  input  logic             m_ie,
  input  logic             s_ie,
  input  logic             vs_ie,
  input  logic [XLEN-1:0]  m_edeleg,
  input  logic [XLEN-1:0]  h_edeleg,
  input  logic [ACT_W-1:0] act_code,
  output logic             allow
);
  logic m_bp_dlg, h_bp_dlg;
  logic ok_mach, ok_supv, ok_vsupv;

  assign m_bp_dlg = m_edeleg[BP_CAUSE];
  assign h_bp_dlg = h_edeleg[BP_CAUSE];

  always_comb begin
    ok_mach  = (priv != PRIV_MACH) || m_ie;
    ok_supv  = (priv != PRIV_SUPV) || virt || !m_bp_dlg || s_ie;
    ok_vsupv = (priv != PRIV_SUPV) || !virt || !m_bp_dlg || !h_bp_dlg || vs_ie;
    if (act_code != ACT_BREAKPOINT) allow = 1'b1;
    else                            allow = ok_mach && ok_supv && ok_vsupv;
  end
endmodule

// File: rtl/trig_cause_decode.sv
module trig_cause_decode #(
  parameter int unsigned XLEN = 32
) (
  input  logic            trap_valid,
  input  logic [XLEN-1:0] trap_cause,
  input  logic [XLEN-1:0] irq_sel,
  input  logic [XLEN-1:0] exc_sel,
  output logic            hit
);
  localparam int unsigned IDX_W = $clog2(XLEN);

  logic            is_irq;
  logic [XLEN-1:0] idx_full;
  logic            in_range;
  logic [IDX_W-1:0] idx;
  logic            sel_bit;

  always_comb begin
    is_irq   = trap_cause[XLEN-1];
    idx_full = trap_cause;
    idx_full[XLEN-1] = 1'b0;
    in_range = (idx_full < XLEN);
    idx      = idx_full[IDX_W-1:0];
    sel_bit  = is_irq ? irq_sel[idx] : exc_sel[idx];
    hit      = trap_valid && in_range && sel_bit;
  end
endmodule

// File: rtl/trig_fire_gate.sv
module trig_fire_gate
  import trig_fire_gate_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       priv,
  input  logic             virt,
  input  logic             m_ie,
  input  logic             s_ie,
  input  logic             vs_ie,
  input  logic [XLEN-1:0]  m_edeleg,
  input  logic [XLEN-1:0]  h_edeleg,
  input  logic [ACT_W-1:0] act_code,
  input  logic             mem_hit,
  input  logic             icnt_hit,
  input  logic             icnt_ctx_ok,
  input  logic             trap_valid,
  input  logic [XLEN-1:0]  trap_cause,
  input  logic [XLEN-1:0]  trap_irq_sel,
  input  logic [XLEN-1:0]  trap_exc_sel,
  output logic             mem_fire,
  output logic             icnt_fire,
  output logic             trap_fire,
  output logic             fire_after
);
  logic allow, trap_raw;
  logic mem_d, icnt_d, trap_d;
  logic mem_q, icnt_q, trap_q;
  logic upd_en;

  trig_reentry_guard #(.XLEN(XLEN)) guard_i (
    .priv(priv), .virt(virt), .m_ie(m_ie), .s_ie(s_ie), .vs_ie(vs_ie),
    .m_edeleg(m_edeleg), .h_edeleg(h_edeleg), .act_code(act_code),
    .allow(allow)
  );

  trig_cause_decode #(.XLEN(XLEN)) decode_i (
    .trap_valid(trap_valid), .trap_cause(trap_cause),
    .irq_sel(trap_irq_sel), .exc_sel(trap_exc_sel), .hit(trap_raw)
  );

  assign upd_en = 1'b1;

  always_comb begin
    mem_d  = mem_hit && allow;
    icnt_d = icnt_hit && icnt_ctx_ok && allow;
    trap_d = trap_raw && allow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q  <= 1'b0;
      icnt_q <= 1'b0;
      trap_q <= 1'b0;
    end else if (upd_en) begin
      mem_q  <= mem_d;
      icnt_q <= icnt_d;
      trap_q <= trap_d;
    end
  end

  assign mem_fire   = mem_q;
  assign icnt_fire  = icnt_q;
  assign trap_fire  = trap_q;
  assign fire_after = trap_q;

  a_r7_mem_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fire |-> $past(mem_hit));
  a_r7_icnt_needs_ctx: assert property (@(posedge clk) disable iff (!rst_n)
    icnt_fire |-> ($past(icnt_ctx_ok) && $past(icnt_hit)));
  a_r3_mach_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (act_code == ACT_BREAKPOINT && priv == PRIV_MACH && !m_ie) |=>
      !(mem_fire || icnt_fire || trap_fire));
  a_r2_other_action_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (act_code != ACT_BREAKPOINT && mem_hit) |=> mem_fire);
  a_r8_trap_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |-> $past(trap_valid));
  a_r10_after_timing: assert property (@(posedge clk) disable iff (!rst_n)
    fire_after == trap_fire);
endmodule

// File: tb/trig_fire_gate_tb.sv
module trig_fire_gate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] priv;
  logic virt, m_ie, s_ie, vs_ie;
  logic [XLEN-1:0] m_edeleg, h_edeleg;
  logic [3:0] act_code;
  logic mem_hit, icnt_hit, icnt_ctx_ok, trap_valid;
  logic [XLEN-1:0] trap_cause, trap_irq_sel, trap_exc_sel;
  logic mem_fire, icnt_fire, trap_fire, fire_after;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_fire_gate #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .priv(priv), .virt(virt), .m_ie(m_ie),
    .s_ie(s_ie), .vs_ie(vs_ie), .m_edeleg(m_edeleg), .h_edeleg(h_edeleg),
    .act_code(act_code), .mem_hit(mem_hit), .icnt_hit(icnt_hit),
    .icnt_ctx_ok(icnt_ctx_ok), .trap_valid(trap_valid), .trap_cause(trap_cause),
    .trap_irq_sel(trap_irq_sel), .trap_exc_sel(trap_exc_sel),
    .mem_fire(mem_fire), .icnt_fire(icnt_fire), .trap_fire(trap_fire),
    .fire_after(fire_after)
  );

  function automatic bit model_ok();
    if (act_code != 4'd0) return 1'b1;
    if (priv == 2'b11) return m_ie;
    if (priv == 2'b01) begin
      if (!virt) return !(m_edeleg[3] && !s_ie);
      return !(m_edeleg[3] && h_edeleg[3] && !vs_ie);
    end
    return 1'b1;
  endfunction

  function automatic bit model_trap();
    longint unsigned idx;
    bit sel;
    idx = longint'(trap_cause) & 64'h7FFF_FFFF;
    if (!trap_valid || idx >= XLEN) return 1'b0;
    sel = trap_cause[XLEN-1] ? trap_irq_sel[idx] : trap_exc_sel[idx];
    return sel;
  endfunction

  task automatic check(input string req, input string name, input bit act, input bit exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, name, act, exp);
    end
  endtask

  // Drive is already set; compute expectation, advance one clock, compare.
  task automatic step(input string req);
    bit ok, e_mem, e_icnt, e_trap;
    ok     = model_ok();
    e_mem  = mem_hit && ok;
    e_icnt = icnt_hit && icnt_ctx_ok && ok;
    e_trap = model_trap() && ok;
    @(negedge clk);
    check(req, "mem_fire", mem_fire, e_mem);
    check(req, "icnt_fire", icnt_fire, e_icnt);
    check(req, "trap_fire", trap_fire, e_trap);
    check(req, "fire_after", fire_after, e_trap);
  endtask

  task automatic set_all_hits();
    mem_hit = 1; icnt_hit = 1; icnt_ctx_ok = 1; trap_valid = 1;
    trap_cause = 32'd5; trap_exc_sel = 32'h20; trap_irq_sel = '0;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total-fails, total);
    $finish;
  end

  initial begin
    rst_n = 0; priv = 2'b11; virt = 0; m_ie = 1; s_ie = 1; vs_ie = 1;
    m_edeleg = '0; h_edeleg = '0; act_code = 0;
    set_all_hits();
    repeat (3) @(negedge clk);
    check("R1", "mem_fire rst", mem_fire, 0);
    check("R1", "trap_fire rst", trap_fire, 0);
    check("R1", "fire_after rst", fire_after, 0);
    rst_n = 1;
    #1;
    check("R1", "icnt_fire after release", icnt_fire, 0);
    @(negedge clk);

    // R3 machine mode
    priv = 2'b11; m_ie = 0; step("R3");
    m_ie = 1; step("R3");
    // R2 non-zero action ignores blocking state
    m_ie = 0; act_code = 4'd1; step("R2");
    act_code = 4'd15; priv = 2'b01; m_edeleg = 32'h8; s_ie = 0; step("R2");
    act_code = 0;
    // R4 supervisor, not virtual
    priv = 2'b01; virt = 0; m_edeleg = 32'h8; s_ie = 0; step("R4");
    s_ie = 1; step("R4");
    s_ie = 0; m_edeleg = 32'hFFFF_FFF7; step("R4");
    // R5 virtual supervisor
    virt = 1; m_edeleg = 32'h8; h_edeleg = 32'h8; vs_ie = 0; s_ie = 1; step("R5");
    vs_ie = 1; step("R5");
    vs_ie = 0; h_edeleg = 32'h0; step("R5");
    h_edeleg = 32'h8; m_edeleg = 32'h0; step("R5");
    // R6 user and reserved code
    m_edeleg = 32'h8; h_edeleg = 32'h8; m_ie = 0; s_ie = 0; vs_ie = 0;
    priv = 2'b00; virt = 0; step("R6");
    virt = 1; step("R6");
    priv = 2'b10; step("R6");
    // R7 count trigger needs context match
    priv = 2'b11; m_ie = 1; icnt_ctx_ok = 0; step("R7");
    icnt_ctx_ok = 1; mem_hit = 0; step("R7");
    mem_hit = 1;
    // R8 cause decode
    trap_cause = 32'h8000_0005; trap_irq_sel = 32'h0; trap_exc_sel = 32'h20; step("R8");
    trap_irq_sel = 32'h20; trap_exc_sel = 32'h0; step("R8");
    trap_cause = 32'h0000_0005; step("R8");
    trap_valid = 0; trap_exc_sel = 32'h20; step("R8");
    trap_valid = 1;
    // R9 range check
    trap_cause = 32'd31; trap_exc_sel = 32'h8000_0000; step("R9");
    trap_cause = 32'd32; trap_exc_sel = 32'hFFFF_FFFF; step("R9");
    trap_cause = 32'h8000_0040; trap_irq_sel = 32'hFFFF_FFFF; step("R9");
    // R10 timing flag with gate blocking trap
    trap_cause = 32'd2; trap_exc_sel = 32'h4; m_ie = 0; step("R10");
    m_ie = 1; step("R10");

    // R11 random stream, compared every clock
    for (int i = 0; i < 3000; i++) begin
      priv = 2'($urandom); virt = 1'($urandom); m_ie = 1'($urandom);
      s_ie = 1'($urandom); vs_ie = 1'($urandom);
      m_edeleg = $urandom; h_edeleg = $urandom;
      act_code = ($urandom % 3 == 0) ? 4'($urandom) : 4'd0;
      mem_hit = 1'($urandom); icnt_hit = 1'($urandom); icnt_ctx_ok = 1'($urandom);
      trap_valid = 1'($urandom);
      trap_cause = {1'($urandom), 31'($urandom % 40)};
      trap_irq_sel = $urandom; trap_exc_sel = $urandom;
      step("R11");
    end

    $display("%0d/%0d checks passed", total-fails, total);
    $finish;
  end
endmodule